// File: doc/BRIEF.md
# BCD Preset Load Sequencer

This block sequences the presetting of a decade counter and a compare register from one shared 4-bit BCD port. The port carries one digit at a time, following the display scan phase. Each of the two load controls arrives already decoded from a three-level pin into low, open or high. A control moving to high starts a load. The block then resets the scan phase to the most significant digit and switches the scan to the internal free-running tick. It issues one write strobe per digit, from the most significant digit down to the least, for as many whole passes as a control stays high.

When neither control is high, the block drives the port with the latched digit that belongs to the current scan phase. A control held low takes the port off the bus. Holding the register control low also stops the scan and blanks the display. All interfaces are plain level or pulse signals. There is no stream data path, so no valid/ready handshake applies.

Top module: `bcd_preset_seq`

## Requirements
- R1: After reset the block is in normal mode: `scan_phase` is 3 (digit D4), there are no write strobes, and `count_inh`, `scan_sel_int` and `phase_rst` are 0.
- R2: In normal mode, a control code moving to high (`2'b10`) from low (`2'b00`) or open (`2'b01`) starts a load. `phase_rst` is 1 in that same cycle. From the next cycle on, `scan_phase` is 3 and `scan_sel_int` is 1.
- R3: During a load, each `int_tick` writes the current phase's digit. The strobe bit index equals `scan_phase`, the phases run 3, 2, 1, 0, and `wr_data` equals `bcd_in` in the strobe cycle.
- R4: At the tick that ends phase 0, the controls are sampled again. If either is high, another pass starts at phase 3. Otherwise normal mode resumes and `scan_sel_int` returns to 0.
- R5: A load started with only the counter control high strobes only `ctr_wr`, and `count_inh` is 1 throughout it.
- R6: A load started with only the register control high strobes only `reg_wr`. `ctr_wr` and `count_inh` stay 0, so the counter is left untouched.
- R7: A load started with both controls high strobes `ctr_wr` and `reg_wr` together, with `count_inh` at 1.
- R8: With both controls open in normal mode, `port_drive` is 1 and `bcd_out` is the nibble of `shown_digits` at bits `[4*scan_phase +: 4]`. Each `ext_tick` steps the phase down by one, wrapping from 0 to 3.
- R9: Either control low makes `port_drive` 0 and `bcd_out` 0. Register control low also makes `disp_en` and `osc_run` 0 and freezes `scan_phase`. Counter control low leaves the display and the scan running.
- R10: `ext_tick` has no effect on the phase during a load. `int_tick` produces no strobe and does not move the phase in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lc_lvl | input | 2 | Counter load control: 00 low, 01 open, 10 high (11 read as open) |
| lr_lvl | input | 2 | Register load control, same code |
| int_tick | input | 1 | Internal free-running oscillator pulse, one cycle wide |
| ext_tick | input | 1 | External scan pulse, one cycle wide |
| bcd_in | input | 4 | Nibble read from the port |
| shown_digits | input | 16 | Latched display digits; D1 in bits 3:0, D4 in bits 15:12 |
| port_drive | output | 1 | 1 = port driven, 0 = high-impedance |
| bcd_out | output | 4 | Nibble driven onto the port |
| wr_data | output | 4 | Digit value that goes with the write strobes |
| ctr_wr | output | 4 | Per-digit counter write strobes |
| reg_wr | output | 4 | Per-digit register write strobes |
| count_inh | output | 1 | Inhibits counting |
| scan_sel_int | output | 1 | 1 = scan runs from `int_tick` |
| phase_rst | output | 1 | Forces the scan phase to D4 |
| scan_phase | output | 2 | Current digit phase (3 = D4, 0 = D1) |
| disp_en | output | 1 | Digit and segment drivers enabled |
| osc_run | output | 1 | Scan oscillator running |

## Verification
The bench builds the block with its default parameters: four digits and 4-bit nibbles. At that size every phase, the 0-to-3 wrap and the repeat pass at the end of phase 0 all come up within a few dozen cycles. The vector table steps the normal-mode scan through open, half-low and frozen states. The directed loads then cover each mode, a two-pass repeat, and ticks from the source that is not selected, which must be ignored.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_OPEN = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;
endpackage

// File: rtl/pseq_lvl_decode.sv
module pseq_lvl_decode
  import pseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  output logic       is_high,
  output logic       is_open,
  output logic       rise
);
  logic was_high;

  assign is_high = (code == LVL_HIGH);
  assign is_open = (code != LVL_HIGH) && (code != LVL_LOW);
  assign rise    = is_high && !was_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_high <= 1'b0;
    else        was_high <= is_high;
  end
endmodule

// File: rtl/pseq_scan_ctr.sv
module pseq_scan_ctr #(
  parameter int DIGITS = 4,
  localparam int PW = $clog2(DIGITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_rst,
  input  logic          sel_int,
  input  logic          int_tick,
  input  logic          ext_tick,
  input  logic          osc_run,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] TOP = PW'(DIGITS - 1);
  logic step;

  assign step = sel_int ? int_tick : (ext_tick && osc_run);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase <= TOP;
    else if (phase_rst)       phase <= TOP;
    else if (step)            phase <= (phase == '0) ? TOP : phase - 1'b1;
  end

  AST_PHASE_TO_D4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst |=> (phase == TOP)); // R2
  AST_SCAN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_int && !osc_run && !phase_rst) |=> $stable(phase)); // R9
endmodule

// File: rtl/pseq_load_fsm.sv
module pseq_load_fsm #(
  parameter int DIGITS = 4,
  localparam int PW = $clog2(DIGITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lc_rise,
  input  logic              lr_rise,
  input  logic              lc_high,
  input  logic              lr_high,
  input  logic              int_tick,
  input  logic [PW-1:0]     phase,
  output logic              loading,
  output logic              ld_ctr,
  output logic              phase_rst,
  output logic [DIGITS-1:0] ctr_wr,
  output logic [DIGITS-1:0] reg_wr
);
  logic ld_reg, start, pass_end, again;

  assign start     = !loading && (lc_rise || lr_rise);
  assign pass_end  = loading && int_tick && (phase == '0);
  assign again     = pass_end && (lc_high || lr_high);
  assign phase_rst = start || again;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading <= 1'b0;
      ld_ctr  <= 1'b0;
      ld_reg  <= 1'b0;
    end else if (start || pass_end) begin
      loading <= start || again;
      ld_ctr  <= lc_high;
      ld_reg  <= lr_high;
    end
  end

  for (genvar i = 0; i < DIGITS; i++) begin : g_strobe
    assign ctr_wr[i] = loading && int_tick && ld_ctr && (phase == PW'(i));
    assign reg_wr[i] = loading && int_tick && ld_reg && (phase == PW'(i));
  end

  AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctr_wr) && $onehot0(reg_wr)); // R3
  AST_STROBE_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (|{ctr_wr, reg_wr}) |-> (loading && int_tick)); // R10
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> loading); // R2
endmodule

// File: rtl/pseq_port_mux.sv
module pseq_port_mux #(
  parameter int DIGITS = 4,
  parameter int NIB    = 4,
  localparam int PW = $clog2(DIGITS)
) (
  input  logic                  drive,
  input  logic [PW-1:0]         phase,
  input  logic [DIGITS*NIB-1:0] digits,
  output logic [NIB-1:0]        nib_out
);
  assign nib_out = drive ? digits[phase*NIB +: NIB] : '0;
endmodule

// File: rtl/bcd_preset_seq.sv
module bcd_preset_seq #(
  parameter int DIGITS = 4,
  parameter int NIB    = 4,
  localparam int PW = $clog2(DIGITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            lc_lvl,
  input  logic [1:0]            lr_lvl,
  input  logic                  int_tick,
  input  logic                  ext_tick,
  input  logic [NIB-1:0]        bcd_in,
  input  logic [DIGITS*NIB-1:0] shown_digits,
  output logic                  port_drive,
  output logic [NIB-1:0]        bcd_out,
  output logic [NIB-1:0]        wr_data,
  output logic [DIGITS-1:0]     ctr_wr,
  output logic [DIGITS-1:0]     reg_wr,
  output logic                  count_inh,
  output logic                  scan_sel_int,
  output logic                  phase_rst,
  output logic [PW-1:0]         scan_phase,
  output logic                  disp_en,
  output logic                  osc_run
);
  logic lc_high, lc_open, lc_rise;
  logic lr_high, lr_open, lr_rise;
  logic loading, ld_ctr, lr_low;

  pseq_lvl_decode u_lc (.clk, .rst_n, .code(lc_lvl),
                        .is_high(lc_high), .is_open(lc_open), .rise(lc_rise));
  pseq_lvl_decode u_lr (.clk, .rst_n, .code(lr_lvl),
                        .is_high(lr_high), .is_open(lr_open), .rise(lr_rise));

  pseq_load_fsm #(.DIGITS(DIGITS)) u_fsm (
    .clk, .rst_n, .lc_rise, .lr_rise, .lc_high, .lr_high, .int_tick,
    .phase(scan_phase), .loading, .ld_ctr, .phase_rst, .ctr_wr, .reg_wr);

  assign lr_low       = !lr_high && !lr_open;
  assign osc_run      = loading || !lr_low;
  assign disp_en      = !lr_low;
  assign scan_sel_int = loading;
  assign count_inh    = loading && ld_ctr;
  assign port_drive   = !loading && lc_open && lr_open;
  assign wr_data      = bcd_in;

  pseq_scan_ctr #(.DIGITS(DIGITS)) u_scan (
    .clk, .rst_n, .phase_rst, .sel_int(loading), .int_tick, .ext_tick,
    .osc_run, .phase(scan_phase));

  pseq_port_mux #(.DIGITS(DIGITS), .NIB(NIB)) u_mux (
    .drive(port_drive), .phase(scan_phase), .digits(shown_digits),
    .nib_out(bcd_out));

  AST_QUIET_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    scan_sel_int |-> !port_drive); // R9
  AST_INH_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    count_inh |-> scan_sel_int); // R5
  AST_REG_LOW_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_sel_int && !osc_run) |-> (!disp_en && !port_drive)); // R9
endmodule

// File: tb/bcd_preset_seq_tb_top.sv
module bcd_preset_seq_tb_top;
  localparam logic [1:0] LO = 2'b00, OP = 2'b01, HI = 2'b10;
  localparam logic [15:0] SHOWN = 16'h9752;

  logic clk = 0, rst_n = 0;
  logic [1:0] lc_lvl = OP, lr_lvl = OP;
  logic int_tick = 0, ext_tick = 0;
  logic [3:0] bcd_in = 0;
  logic port_drive, count_inh, scan_sel_int, phase_rst, disp_en, osc_run;
  logic [3:0] bcd_out, wr_data, ctr_wr, reg_wr;
  logic [1:0] scan_phase;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bcd_preset_seq dut_i (.clk, .rst_n, .lc_lvl, .lr_lvl, .int_tick, .ext_tick,
    .bcd_in, .shown_digits(SHOWN), .port_drive, .bcd_out, .wr_data, .ctr_wr,
    .reg_wr, .count_inh, .scan_sel_int, .phase_rst, .scan_phase, .disp_en,
    .osc_run);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {lc, lr, ext ticks, expected phase, drive, disp}
  typedef struct packed {
    logic [1:0] lc; logic [1:0] lr; logic [2:0] n;
    logic [1:0] ph; logic drv; logic dsp;
  } vec_t;
  localparam vec_t VECS [7] = '{
    '{OP, OP, 3'd1, 2'd2, 1'b1, 1'b1},
    '{OP, OP, 3'd2, 2'd0, 1'b1, 1'b1},
    '{OP, OP, 3'd1, 2'd3, 1'b1, 1'b1},
    '{LO, OP, 3'd2, 2'd1, 1'b0, 1'b1},
    '{OP, LO, 3'd3, 2'd1, 1'b0, 1'b0},
    '{LO, LO, 3'd1, 2'd1, 1'b0, 1'b0},
    '{OP, OP, 3'd1, 2'd0, 1'b1, 1'b1}
  };

  task automatic start_load(input logic [1:0] lc, input logic [1:0] lr);
    @(negedge clk); lc_lvl = lc; lr_lvl = lr;
    #1 chk(phase_rst == 1, "R2 phase_rst on edge", phase_rst, 1);
    @(negedge clk);
    chk(scan_sel_int == 1 && scan_phase == 3, "R2 internal scan at D4",
        {scan_sel_int, scan_phase}, 3'b111);
  endtask

  task automatic load_pass(input bit ec, input bit er, input logic [15:0] d, input bit drop);
    for (int k = 0; k < 4; k++) begin
      int idx = 3 - k;
      @(negedge clk);
      ext_tick = 0;
      if (drop && k == 3) begin lc_lvl = OP; lr_lvl = OP; end
      bcd_in = d[idx*4 +: 4]; int_tick = 1;
      #1;
      chk(scan_phase == 2'(idx), "R3 R10 phase order", scan_phase, idx);
      chk(ctr_wr == (ec ? 4'(1 << idx) : 4'd0), ec ? "R5 R7 ctr strobe" : "R6 no ctr strobe", ctr_wr, ec ? (1 << idx) : 0);
      chk(reg_wr == (er ? 4'(1 << idx) : 4'd0), er ? "R6 R7 reg strobe" : "R5 no reg strobe", reg_wr, er ? (1 << idx) : 0);
      chk(wr_data == d[idx*4 +: 4], "R3 wr_data", wr_data, d[idx*4 +: 4]);
      chk(count_inh == ec, "R5 R6 R7 count_inh", count_inh, ec);
      @(negedge clk); int_tick = 0;
      if (k == 0) ext_tick = 1;
    end
    ext_tick = 0;
  endtask

  initial begin
    #(100000 * 20);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #35 rst_n = 1;
    @(negedge clk);
    chk(scan_phase == 3 && ctr_wr == 0 && reg_wr == 0, "R1 reset phase/strobes",
        {scan_phase, ctr_wr, reg_wr}, 10'h300);
    chk({count_inh, scan_sel_int, phase_rst} == 0, "R1 reset controls",
        {count_inh, scan_sel_int, phase_rst}, 0);

    foreach (VECS[i]) begin
      @(negedge clk); lc_lvl = VECS[i].lc; lr_lvl = VECS[i].lr;
      for (int t = 0; t < VECS[i].n; t++) begin
        @(negedge clk); ext_tick = 1;
        @(negedge clk); ext_tick = 0;
      end
      #1;
      chk(scan_phase == VECS[i].ph, "R8 R9 scan phase", scan_phase, VECS[i].ph);
      chk(port_drive == VECS[i].drv, "R8 R9 port_drive", port_drive, VECS[i].drv);
      chk(disp_en == VECS[i].dsp && osc_run == VECS[i].dsp, "R9 disp/osc",
          {disp_en, osc_run}, {VECS[i].dsp, VECS[i].dsp});
      chk(bcd_out == (VECS[i].drv ? SHOWN[VECS[i].ph*4 +: 4] : 4'd0), "R8 R9 bcd_out",
          bcd_out, VECS[i].drv ? SHOWN[VECS[i].ph*4 +: 4] : 0);
    end

    // R10: int_tick in normal mode is ignored; R9: counter control low
    @(negedge clk); lc_lvl = LO;
    @(negedge clk); int_tick = 1;
    #1 chk(ctr_wr == 0 && reg_wr == 0, "R10 R9 no strobe when idle", {ctr_wr, reg_wr}, 0);
    @(negedge clk); int_tick = 0;
    chk(scan_phase == 0, "R10 int_tick ignored idle", scan_phase, 0);
    chk(disp_en == 1 && port_drive == 0, "R9 lc low display on, port off",
        {disp_en, port_drive}, 2'b10);

    // R5: counter only, one pass
    start_load(HI, OP);
    load_pass(1, 0, 16'h3816, 1);
    #1 chk(scan_sel_int == 0 && count_inh == 0, "R4 R5 back to normal",
           {scan_sel_int, count_inh}, 0);

    // R6: register only; counter untouched
    start_load(OP, HI);
    load_pass(0, 1, 16'h0429, 1);
    #1 chk(scan_sel_int == 0, "R4 R6 back to normal", scan_sel_int, 0);

    // R7 + R4: both high, two passes
    start_load(HI, HI);
    load_pass(1, 1, 16'h5170, 0);
    #1 chk(scan_sel_int == 1 && scan_phase == 3, "R4 repeat pass at D4",
           {scan_sel_int, scan_phase}, 3'b111);
    load_pass(1, 1, 16'h8642, 1);
    #1 chk(scan_sel_int == 0 && port_drive == 1, "R4 R8 normal after repeat",
           {scan_sel_int, port_drive}, 2'b01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule